// File: doc/BRIEF.md
# Recency Stack with Random Victim Pick

This block keeps a short, ordered list of the physical frame numbers touched most recently, with the newest at the top. Each reference it sees does one of two things. If the frame is already in the list, that entry is lifted to the top. If it is not, the frame is pushed onto the top, and the oldest entry falls off the bottom once every slot is in use.

When the page-fault logic needs a frame to reclaim, it raises a victim request. The block answers with a frame number that is not in the list, so frames used recently are protected from eviction. It finds that frame by starting at a pseudo-random index taken from a free-running 16-bit LFSR and walking upward through the frame numbers, wrapping at the frame count. It tests one candidate per cycle. If every frame is in the list, which can only happen when the frame count is no larger than the list depth, it reports an error instead.

Top module: `lru_ref_stack`

## Requirements
- R1: While `rst` is high at a clock edge, the list is emptied, the LFSR returns to its seed and both `vic_valid` and `vic_error` are low in the following cycle; after reset, every frame counts as absent.
- R2: A cycle with `ref_valid` high places `ref_frame` at the top of the list at the next edge.
- R3: When the referenced frame is already in the list, it moves to the top, the entries that were above it each move down one place, and the entries below it stay where they are; no frame leaves the list.
- R4: When the referenced frame is absent and all `STACK_DEPTH` slots are in use, the bottom entry is dropped.
- R5: When the referenced frame is absent and a slot is free, the frame is added without dropping anything. Empty slots never count as holding a frame.
- R6: A victim search starts at the LFSR value modulo `NUM_FRAMES`. It tests one index per cycle, stepping by one and wrapping from `NUM_FRAMES-1` to 0, and returns the first index absent from the list at the moment it is tested. The returned value is always below `NUM_FRAMES`.
- R7: `vic_valid` is high for exactly one cycle, with `vic_frame` holding the chosen frame. The earliest it can rise is the second clock edge after the request is sampled, and the search tests at most `NUM_FRAMES` candidates.
- R8: If a reference and a victim request come in the same cycle, the reference updates the list first, and the search runs against the updated list from the next cycle on.
- R9: If all `NUM_FRAMES` candidates are found in the list, `vic_error` pulses high for one cycle and `vic_valid` stays low.
- R10: A victim request that arrives while a search is already running is ignored and does not start a second response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_valid | input | 1 | A frame reference is present this cycle |
| ref_frame | input | FW = clog2(NUM_FRAMES) | Frame number being referenced |
| vic_req | input | 1 | Request for a victim frame |
| vic_valid | output | 1 | One-cycle pulse: `vic_frame` holds the chosen victim |
| vic_frame | output | FW | Frame number of the chosen victim |
| vic_error | output | 1 | One-cycle pulse: every frame is in the list |

## Verification
The main instance has a list depth of 4 and 5 frames. Once its list is full, exactly one frame is missing, so every victim answer identifies that frame exactly. A stream of references that mixes hits at each depth with misses therefore shows whether a hit promotes its entry, and which entry a miss drops. While the list is still filling, answers are checked only for being absent from a reference model.

A second instance has 4 frames and a depth of 4. It is used to separate a partly filled list from a full one, which must raise the error pulse. Two further cases are covered: a reference arriving in the same cycle as a request, and a request repeated while a search is running.

// File: rtl/lru_ref_stack.sv
module lru_ref_stack #(
  parameter int STACK_DEPTH = 16,
  parameter int NUM_FRAMES  = 64,
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   ref_valid,
  input  logic [$clog2(NUM_FRAMES)-1:0]          ref_frame,
  input  logic                                   vic_req,
  output logic                                   vic_valid,
  output logic [$clog2(NUM_FRAMES)-1:0]          vic_frame,
  output logic                                   vic_error
);
  localparam int FW = $clog2(NUM_FRAMES);
  localparam int IW = (STACK_DEPTH > 1) ? $clog2(STACK_DEPTH) : 1;
  localparam int CW = $clog2(NUM_FRAMES + 1);

  logic [FW-1:0]          stk [STACK_DEPTH];
  logic [STACK_DEPTH-1:0] vld;
  logic [15:0]            lfsr;
  logic                   scanning;
  logic [FW-1:0]          cand;
  logic [CW-1:0]          tested;

  logic          hit;
  logic [IW-1:0] hit_idx;
  logic          cand_in;

  always_comb begin
    hit     = 1'b0;
    hit_idx = IW'(STACK_DEPTH - 1);
    cand_in = 1'b0;
    for (int i = STACK_DEPTH - 1; i >= 0; i--) begin
      if (vld[i] && stk[i] == ref_frame) begin
        hit     = 1'b1;
        hit_idx = IW'(i);
      end
      if (vld[i] && stk[i] == cand) cand_in = 1'b1;
    end
  end

  wire [FW-1:0] cand_start = FW'(32'(lfsr) % NUM_FRAMES);
  wire [FW-1:0] cand_next  = (cand == FW'(NUM_FRAMES - 1)) ? '0 : cand + 1'b1;
  wire          lfsr_fb    = lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10];

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
      for (int i = 0; i < STACK_DEPTH; i++) stk[i] <= '0;
    end else if (ref_valid) begin
      for (int i = 1; i < STACK_DEPTH; i++) begin
        if (i <= int'(hit_idx)) begin
          stk[i] <= stk[i-1];
          vld[i] <= vld[i-1];
        end
      end
      stk[0] <= ref_frame;
      vld[0] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lfsr      <= LFSR_SEED;
      scanning  <= 1'b0;
      cand      <= '0;
      tested    <= '0;
      vic_valid <= 1'b0;
      vic_error <= 1'b0;
      vic_frame <= '0;
    end else begin
      lfsr      <= {lfsr[14:0], lfsr_fb};
      vic_valid <= 1'b0;
      vic_error <= 1'b0;
      if (!scanning) begin
        if (vic_req) begin
          scanning <= 1'b1;
          cand     <= cand_start;
          tested   <= '0;
        end
      end else if (!cand_in) begin
        vic_valid <= 1'b1;
        vic_frame <= cand;
        scanning  <= 1'b0;
      end else if (tested == CW'(NUM_FRAMES - 1)) begin
        vic_error <= 1'b1;
        scanning  <= 1'b0;
      end else begin
        cand   <= cand_next;
        tested <= tested + 1'b1;
      end
    end
  end

  // R2
  top_push_chk: assert property (@(posedge clk) disable iff (rst)
    ref_valid |=> (vld[0] && stk[0] == $past(ref_frame)));

  // R7
  vic_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    vic_valid |=> !vic_valid);

  // R9
  err_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(vic_valid && vic_error));

  // R9
  err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    vic_error |=> !vic_error);

  // R6
  vic_range_chk: assert property (@(posedge clk) disable iff (rst)
    vic_valid |-> int'(vic_frame) < NUM_FRAMES);

  // R10
  no_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (scanning && cand_in && tested != CW'(NUM_FRAMES - 1)) |=> scanning);
endmodule

// File: tb/tb_lru_ref_stack.sv
module tb_lru_ref_stack;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] rv  = '0;
  logic [1:0] vq  = '0;
  logic [2:0] rfa = '0;
  logic [1:0] rfb = '0;
  logic [1:0] vv, ve;
  logic [2:0] vfa;
  logic [1:0] vfb;

  always #2.5 clk = ~clk;

  lru_ref_stack #(.STACK_DEPTH(4), .NUM_FRAMES(5)) dut (
    .clk(clk), .rst(rst), .ref_valid(rv[0]), .ref_frame(rfa),
    .vic_req(vq[0]), .vic_valid(vv[0]), .vic_frame(vfa), .vic_error(ve[0]));

  lru_ref_stack #(.STACK_DEPTH(4), .NUM_FRAMES(4)) dut_full (
    .clk(clk), .rst(rst), .ref_valid(rv[1]), .ref_frame(rfb),
    .vic_req(vq[1]), .vic_valid(vv[1]), .vic_frame(vfb), .vic_error(ve[1]));

  int nchk = 0, nfail = 0;
  int ms [2][4];
  int mn [2] = '{0, 0};
  int nfr [2] = '{5, 4};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit in_model(input int s, input int f);
    for (int i = 0; i < mn[s]; i++) if (ms[s][i] == f) return 1'b1;
    return 1'b0;
  endfunction

  function automatic void model_ref(input int s, input int f);
    int h = -1;
    for (int i = 0; i < mn[s]; i++) if (ms[s][i] == f) h = i;
    if (h < 0) begin
      if (mn[s] < 4) mn[s]++;
      h = mn[s] - 1;
    end
    for (int i = h; i > 0; i--) ms[s][i] = ms[s][i-1];
    ms[s][0] = f;
  endfunction

  task automatic drive(input int s, input bit r, input int f, input bit q);
    @(negedge clk);
    rv[s] = r; vq[s] = q;
    if (s == 0) rfa = 3'(f); else rfb = 2'(f);
  endtask

  task automatic collect(input int s, input string req, input bit chk_lat);
    int absent = 0, only = -1, t = 0, got;
    for (int f = 0; f < nfr[s]; f++) if (!in_model(s, f)) begin absent++; only = f; end
    while (t < 12 && !vv[s] && !ve[s]) begin @(negedge clk); t++; end
    got = (s == 0) ? int'(vfa) : int'(vfb);
    if (chk_lat) check(t >= 1 && t <= nfr[s] + 1, "R7 latency", t, 1);
    if (absent == 0) begin
      check(ve[s] && !vv[s], "R9 error pulse", int'(ve[s]), 1);
    end else begin
      check(vv[s] && !ve[s], {req, " valid"}, int'(vv[s]), 1);
      check(!in_model(s, got) && got < nfr[s], {req, " R6 absent"}, got, only);
      if (absent == 1) check(got == only, {req, " exact victim"}, got, only);
    end
    @(negedge clk);
    check(!vv[s] && !ve[s], "R7 one-cycle pulse", int'(vv[s] | ve[s]), 0);
  endtask

  task automatic do_ref(input int s, input int f);
    drive(s, 1'b1, f, 1'b0);
    drive(s, 1'b0, 0, 1'b0);
    model_ref(s, f);
  endtask

  task automatic ask(input int s, input string req);
    drive(s, 1'b0, 0, 1'b1);
    drive(s, 1'b0, 0, 1'b0);
    collect(s, req, 1'b1);
  endtask

  initial begin
    #1000000;
    nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1
    check(vv == 2'b00 && ve == 2'b00, "R1 outputs after reset", int'({vv, ve}), 0);
    ask(1, "R1 empty list");
    ask(0, "R1 empty list");

    // R3 R4 R5: sweep of hits and misses over the 5-frame instance
    for (int i = 0; i < 40; i++) begin
      do_ref(0, (i * 3 + i / 7) % 5);
      ask(0, "R3 R4 R5 sweep");
    end

    // R3: promoting frame 0 makes frame 1 the bottom, so the next miss drops 1
    for (int f = 0; f < 4; f++) do_ref(0, f);
    do_ref(0, 0);
    ask(0, "R3 hit keeps absent 4");
    do_ref(0, 4);
    ask(0, "R3 R4 drop after promote");
    check(!in_model(0, 0) == 1'b0, "R3 promoted kept", 0, 1);

    // R8: reference and request in the same cycle
    begin
      int miss = -1;
      for (int f = 0; f < 5; f++) if (!in_model(0, f)) miss = f;
      drive(0, 1'b1, miss, 1'b1);
      drive(0, 1'b0, 0, 1'b0);
      model_ref(0, miss);
      collect(0, "R8 same cycle", 1'b1);
    end

    // R10: a second request during the search gives no second answer
    drive(0, 1'b0, 0, 1'b1);
    drive(0, 1'b0, 0, 1'b1);
    drive(0, 1'b0, 0, 1'b0);
    collect(0, "R10 first answer", 1'b0);
    begin
      int extra = 0;
      for (int t = 0; t < 10; t++) begin @(negedge clk); if (vv[0] || ve[0]) extra++; end
      check(extra == 0, "R10 no second answer", extra, 0);
    end

    // R5 R9 on the 4-frame instance
    for (int f = 0; f < 3; f++) do_ref(1, f);
    ask(1, "R5 partly filled");
    do_ref(1, 3);
    ask(1, "R9 all present");
    do_ref(1, 1);
    ask(1, "R9 still full after hit");

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule